// File: doc/BRIEF.md
# Transmit Frame Assembler and Output Latch

This block produces the byte stream that a ring station puts on the medium. Each byte is a pair of 4-bit symbols. When a send request arrives, a sequencer builds a frame in a fixed order. It first emits a run of idle pairs, then the start delimiter and the frame control byte. The destination and source addresses follow, then the host's information bytes and a 32-bit check sequence. The frame ends with the end delimiter and three status indicator pairs. Each byte is taken from the source that owns that field: the address inputs, the host byte port or the internal check generator.

On every byte clock, one of three values goes into a single output register: the assembled frame byte, an idle pair, or the byte arriving from the receive path. That register drives the external symbol-pair bus, so a selected byte appears one clock after the cycle in which it was chosen. Abort and repeat inputs take priority over frame assembly. Line encoding and token timing belong to other blocks.

Top module: `tx_frame_assembler`

## Requirements
- R1: While `rst_n` is low, and after reset with no request pending, `txd` holds the idle pair 8'hFF and `busy` is 0.
- R2: A `send` sampled high while the sequencer is idle starts a frame, provided `abort` and `repeat_en` are both low. From the next clock on, `txd` carries these bytes in order, one per clock, each one clock after it is selected: the preamble idles (8'hFF), the start delimiter 8'hC8 (J=4'hC, K=4'h8), `fc`, `da` most significant byte first (6 bytes), `sa` most significant byte first (6 bytes), the information bytes, the check sequence (4 bytes), the end delimiter 8'hDD (two T symbols, T=4'hD), and the three status pairs.
- R3: The preamble has `max(pre_len, 8)` idle pairs.
- R4: The check sequence is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. Bytes are fed most significant bit first over the fields from `fc` through the last information byte. The register is complemented and sent most significant byte first.
- R5: The status pairs go out in the order E, A, C. Each one is 8'h77 (set symbol 4'h7, twice) when its request input `ind_e`, `ind_a` or `ind_c` is 1, and 8'h11 (reset symbol 4'h1, twice) when it is 0.
- R6: `info_take` is high in exactly the `info_len` clocks that select information bytes. The byte on `info_data` in such a clock is the one sent, and the host advances after each such clock. With `info_len` = 0 the check sequence follows the source address directly.
- R7: With `repeat_en` high and `abort` low, `txd` equals the `rx_byte` of the previous clock. Any frame in progress is dropped, `busy` is 0 on the next clock, and `send` is ignored.
- R8: An `abort` sampled high makes `txd` 8'hFF from the next clock onward and returns the sequencer to idle (`busy` 0). `abort` takes priority over `repeat_en`.
- R9: A `send` that arrives while a frame is in progress has no effect on that frame's bytes.
- R10: `busy` is 1 from the clock after a frame starts until the clock in which the last status pair appears on `txd`, and 0 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send | input | 1 | Request to transmit one frame |
| abort | input | 1 | Force idle output and stop the frame |
| repeat_en | input | 1 | Pass received bytes straight through |
| rx_byte | input | 8 | Byte from the receive path |
| pre_len | input | LEN_W | Requested count of preamble idle pairs |
| info_len | input | LEN_W | Number of information bytes |
| fc | input | 8 | Frame control byte |
| da | input | 48 | Destination address |
| sa | input | 48 | Source address |
| info_data | input | 8 | Current information byte from the host |
| ind_e | input | 1 | Error indicator request (1 = set) |
| ind_a | input | 1 | Address-recognised indicator request (1 = set) |
| ind_c | input | 1 | Copied indicator request (1 = set) |
| info_take | output | 1 | Information byte consumed this clock |
| busy | output | 1 | Frame in progress |
| txd | output | 8 | Registered symbol pair to the external bus |

## Verification
The bench compares whole frames byte by byte against a stream it builds itself. A design that dropped or added one latch stage would shift every byte, and a design that sent the addresses or the check sequence in the wrong byte order would fail at those positions. The frames cover a short requested preamble, which must be raised to 8 pairs, and an empty information field, which must not emit a stray byte or stall waiting for host data. Other frames mix set and reset indicators to catch swapped status positions. Abort and repeat are applied in the middle of a frame, and a second send is pulsed during a frame. A design that kept sequencing after abort or repeat, or that restarted on a late send, would put frame bytes on `txd` where idles or received bytes belong.

// File: rtl/tx_frame_assembler.sv
module tx_frame_assembler #(
  parameter int LEN_W   = 8,
  parameter int MIN_PRE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send,
  input  logic             abort,
  input  logic             repeat_en,
  input  logic [7:0]       rx_byte,
  input  logic [LEN_W-1:0] pre_len,
  input  logic [LEN_W-1:0] info_len,
  input  logic [7:0]       fc,
  input  logic [47:0]      da,
  input  logic [47:0]      sa,
  input  logic [7:0]       info_data,
  input  logic             ind_e,
  input  logic             ind_a,
  input  logic             ind_c,
  output logic             info_take,
  output logic             busy,
  output logic [7:0]       txd
);
  localparam logic [7:0]  IDLE_P = 8'hFF;
  localparam logic [7:0]  JK_P   = 8'hC8;
  localparam logic [7:0]  TT_P   = 8'hDD;
  localparam logic [7:0]  SET_P  = 8'h77;
  localparam logic [7:0]  RST_P  = 8'h11;
  localparam logic [31:0] POLY   = 32'h04C11DB7;

  typedef enum logic [3:0] {S_IDLE, S_PRE, S_SD, S_FC, S_DA, S_SA, S_INFO, S_CRC, S_ED, S_FS} st_t;

  st_t              st;
  logic [LEN_W-1:0] cnt;
  logic [31:0]      crc;
  logic [7:0]       sel;
  logic [LEN_W-1:0] pre_eff;
  logic [2:0]       abyte;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  assign pre_eff   = (pre_len < LEN_W'(MIN_PRE)) ? LEN_W'(MIN_PRE) : pre_len;
  assign abyte     = 3'd5 - cnt[2:0];
  assign info_take = (st == S_INFO);
  assign busy      = (st != S_IDLE);

  always_comb begin
    case (st)
      S_SD:    sel = JK_P;
      S_FC:    sel = fc;
      S_DA:    sel = da[8*abyte +: 8];
      S_SA:    sel = sa[8*abyte +: 8];
      S_INFO:  sel = info_data;
      S_CRC:   sel = ~crc[31:24];
      S_ED:    sel = TT_P;
      S_FS: begin
        case (cnt[1:0])
          2'd0:    sel = ind_e ? SET_P : RST_P;
          2'd1:    sel = ind_a ? SET_P : RST_P;
          default: sel = ind_c ? SET_P : RST_P;
        endcase
      end
      default: sel = IDLE_P;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      crc <= '1;
      txd <= IDLE_P;
    end else begin
      txd <= abort ? IDLE_P : (repeat_en ? rx_byte : sel);
      if (abort || repeat_en) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        case (st)
          S_IDLE: begin
            cnt <= '0;
            if (send) st <= S_PRE;
          end
          S_PRE: if (cnt == pre_eff - 1'b1) st <= S_SD;
          S_SD: begin
            crc <= '1;
            st  <= S_FC;
          end
          S_FC: begin
            crc <= crc_byte(crc, sel);
            cnt <= '0;
            st  <= S_DA;
          end
          S_DA: begin
            crc <= crc_byte(crc, sel);
            if (cnt == LEN_W'(5)) begin
              cnt <= '0;
              st  <= S_SA;
            end
          end
          S_SA: begin
            crc <= crc_byte(crc, sel);
            if (cnt == LEN_W'(5)) begin
              cnt <= '0;
              st  <= (info_len == '0) ? S_CRC : S_INFO;
            end
          end
          S_INFO: begin
            crc <= crc_byte(crc, sel);
            if (cnt == info_len - 1'b1) begin
              cnt <= '0;
              st  <= S_CRC;
            end
          end
          S_CRC: begin
            crc <= {crc[23:0], 8'h00};
            if (cnt == LEN_W'(3)) st <= S_ED;
          end
          S_ED: begin
            cnt <= '0;
            st  <= S_FS;
          end
          S_FS: if (cnt == LEN_W'(2)) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module tx_frame_assembler_chk #(
  parameter int LEN_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       send,
  input logic       abort,
  input logic       repeat_en,
  input logic [7:0] rx_byte,
  input logic       info_take,
  input logic       busy,
  input logic [7:0] txd
);
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (txd == 8'hFF) && !busy);

  a_r7_repeat_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (repeat_en && !abort) |=> (txd == $past(rx_byte)) && !busy);

  a_r1_idle_output: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !abort && !repeat_en) |=> (txd == 8'hFF));

  a_r2_send_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && send && !abort && !repeat_en) |=> busy);

  a_r6_take_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    info_take |-> busy);
endmodule

bind tx_frame_assembler tx_frame_assembler_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_tx_frame_assembler.sv
`timescale 1ns/1ps
module sim_tx_frame_assembler;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        send = 0, abort = 0, repeat_en = 0;
  logic [7:0]  rx_byte = 0;
  logic [7:0]  pre_len = 8, info_len = 0, fc = 8'h50;
  logic [47:0] da = 48'h0123_4567_89AB, sa = 48'hA1B2_C3D4_E5F6;
  logic [7:0]  info_data;
  logic        ind_e = 0, ind_a = 0, ind_c = 0;
  logic        info_take, busy;
  logic [7:0]  txd;

  int checks = 0, failures = 0;
  logic [7:0] info_mem [0:63];
  int info_idx = 0;
  logic [7:0] exp_q [$];

  always #2 clk = ~clk;

  tx_frame_assembler u0 (.*);

  assign info_data = info_mem[info_idx[5:0]];
  always @(posedge clk) if (info_take) info_idx <= info_idx + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] x;
    x = c ^ {d, 24'h0};
    for (int k = 0; k < 8; k++) x = x[31] ? ((x << 1) ^ 32'h04C11DB7) : (x << 1);
    return x;
  endfunction

  task automatic build(input int pl, input int il);
    logic [31:0] c;
    exp_q.delete();
    for (int i = 0; i < ((pl < 8) ? 8 : pl); i++) exp_q.push_back(8'hFF);
    exp_q.push_back(8'hC8);
    c = 32'hFFFF_FFFF;
    exp_q.push_back(fc); c = ref_crc(c, fc);
    for (int i = 5; i >= 0; i--) begin exp_q.push_back(da[8*i +: 8]); c = ref_crc(c, da[8*i +: 8]); end
    for (int i = 5; i >= 0; i--) begin exp_q.push_back(sa[8*i +: 8]); c = ref_crc(c, sa[8*i +: 8]); end
    for (int i = 0; i < il; i++) begin exp_q.push_back(info_mem[i]); c = ref_crc(c, info_mem[i]); end
    c = ~c;
    for (int i = 3; i >= 0; i--) exp_q.push_back(c[8*i +: 8]);
    exp_q.push_back(8'hDD);
    exp_q.push_back(ind_e ? 8'h77 : 8'h11);
    exp_q.push_back(ind_a ? 8'h77 : 8'h11);
    exp_q.push_back(ind_c ? 8'h77 : 8'h11);
  endtask

  task automatic start_frame(input int pl, input int il);
    pre_len = 8'(pl); info_len = 8'(il);
    @(negedge clk); info_idx = 0; send = 1;
    @(negedge clk); send = 0;
  endtask

  task automatic t_frame(input string req, input int pl, input int il, input bit late_send);
    int bad = 0;
    build(pl, il);
    start_frame(pl, il);
    chk("R2 idle before first byte", txd, 8'hFF);
    foreach (exp_q[i]) begin
      @(negedge clk);
      if (late_send) send = (i == 20);
      checks++;
      if (txd !== exp_q[i]) begin
        failures++;
        $display("FAIL %s byte %0d actual=%02h expected=%02h", req, i, txd, exp_q[i]);
      end
    end
    send = 0;
    chk("R10 busy clear after last status", {7'h0, busy}, 8'h0);
    @(negedge clk);
    chk("R1 idle after frame", txd, 8'hFF);
    chk("R6 host bytes taken", 8'(info_idx), 8'(il));
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset txd", txd, 8'hFF);
    chk("R1 reset busy", {7'h0, busy}, 8'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", txd, 8'hFF);
  endtask

  task automatic t_abort;
    start_frame(8, 4);
    repeat (12) @(negedge clk);
    chk("R8 busy mid frame", {7'h0, busy}, 8'h1);
    abort = 1; repeat_en = 1; rx_byte = 8'h5A;
    @(negedge clk); abort = 0; repeat_en = 0;
    chk("R8 abort idle output", txd, 8'hFF);
    chk("R8 abort clears busy", {7'h0, busy}, 8'h0);
    @(negedge clk);
    chk("R8 stays idle", txd, 8'hFF);
  endtask

  task automatic t_repeat;
    repeat_en = 1; rx_byte = 8'h3C; send = 1;
    @(negedge clk);
    chk("R7 pass byte", txd, 8'h3C);
    chk("R7 send ignored", {7'h0, busy}, 8'h0);
    rx_byte = 8'hA5;
    @(negedge clk); send = 0;
    chk("R7 pass second byte", txd, 8'hA5);
    repeat_en = 0;
    @(negedge clk);
    chk("R7 no frame after repeat", txd, 8'hFF);
    start_frame(8, 2);
    repeat (15) @(negedge clk);
    repeat_en = 1; rx_byte = 8'h96;
    @(negedge clk); repeat_en = 0;
    chk("R7 repeat mid frame", txd, 8'h96);
    chk("R7 frame dropped", {7'h0, busy}, 8'h0);
    @(negedge clk);
    chk("R7 idle after drop", txd, 8'hFF);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) info_mem[i] = 8'((i * 37 + 11) ^ 8'h5C);
    t_reset();
    ind_e = 0; ind_a = 1; ind_c = 1;
    t_frame("R2 R4 R5 R6 basic frame", 8, 5, 0);
    ind_e = 1; ind_a = 0; ind_c = 1;
    fc = 8'hC3; da = 48'hFFFF_0000_1234;
    t_frame("R3 short preamble raised", 3, 3, 0);
    ind_e = 0; ind_a = 0; ind_c = 0;
    t_frame("R6 empty info field", 10, 0, 0);
    ind_e = 1; ind_a = 1; ind_c = 0;
    t_frame("R9 late send ignored", 9, 2, 1);
    t_abort();
    t_repeat();
    t_frame("R2 frame after abort and repeat", 8, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule